// File: doc/BRIEF.md
# Frame-Synchronous Dword Scrambler

This block whitens a stream of 32-bit dwords. It XORs each data dword with a 32-bit pseudorandom mask taken from a 16-bit linear feedback shift register. The register steps 32 times for every data dword, so each dword gets a fresh mask. A frame-start strobe loads the register with all ones. Because of this, the transmit side and the receive side start every frame from the same point. Scrambling and descrambling are the same operation, so one module serves both directions.

On transmit, the block sits after CRC generation and before line encoding. On receive, it sits in the mirror position. Primitive dwords are flagged by the caller. They pass through unchanged and leave the register where it was. Cycles without valid data also leave it where it was.

Top module: `scr_dword_top`

## Requirements
- R1: While `rst` is high, `out_vld` and `out_dword` go to 0 at the next clock and the register takes the seed 16'hFFFF. The first data dword after reset therefore uses the seed mask even when no frame start was given.
- R2: Output is registered with one cycle of latency: `out_vld` equals `in_vld` from the previous cycle.
- R3: For a data dword (`in_vld`=1, `in_prim`=0), `out_dword` = `in_dword` XOR mask. Mask bit i (i = 0 for the least significant bit) is bit 15 of the register before step i. One step is a left shift by one, XORed with 16'hA011 when the bit shifted out was 1. This is the polynomial x^16+x^15+x^13+x^4+1.
- R4: When `in_sof` is 1, the register is loaded with 16'hFFFF. A data dword in the same cycle, or the first one after it, is scrambled with the mask produced by that seed.
- R5: A primitive dword (`in_vld`=1, `in_prim`=1) appears unchanged on `out_dword` and does not advance the register.
- R6: A cycle with `in_vld`=0 and no frame start leaves the register unchanged, so the next data dword continues the sequence.
- R7: Successive data dwords in a frame use successive masks: each data dword advances the register by exactly 32 steps.
- R8: Passing scrambled output back through the block, with the same frame starts, recovers the original dwords.
- R9: When `in_vld` is 0, `out_dword` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sof | input | 1 | Frame-start strobe; reseeds the register |
| in_vld | input | 1 | Input dword is present this cycle |
| in_prim | input | 1 | Input dword is a primitive; bypass and no advance |
| in_dword | input | 32 | Input dword |
| out_vld | output | 1 | Output dword valid |
| out_dword | output | 32 | Scrambled or recovered dword |

## Verification
The assertions check on every cycle that the valid output lags the input by one cycle, that primitives pass unchanged, and that the output holds when no dword is valid. They also check that the register stays still when it has no reason to move, and that the first data dword of a frame gets the seed mask. The exact mask values for later dwords come from a bit-serial model in the bench, walked over a table of mixed frames. Round-trip recovery, the seed after reset and long idle gaps inside a frame can only be shown by the bench scenarios.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int          SCR_DW   = 32;
    localparam int          SCR_LW   = 16;
    localparam logic [15:0] SCR_POLY = 16'hA011;
    localparam logic [15:0] SCR_SEED = 16'hFFFF;

    typedef struct packed {
        logic              sof;
        logic              vld;
        logic              prim;
        logic [SCR_DW-1:0] data;
    } scr_beat_t;

    // One Galois step of the register.
    function automatic logic [SCR_LW-1:0] lfsr_step(input logic [SCR_LW-1:0] s);
        return {s[SCR_LW-2:0], 1'b0} ^ (s[SCR_LW-1] ? SCR_POLY : '0);
    endfunction

    // Mask produced by the seed, used by the checker.
    function automatic logic [SCR_DW-1:0] seed_mask();
        logic [SCR_LW-1:0] s;
        logic [SCR_DW-1:0] m;
        s = SCR_SEED;
        m = '0;
        for (int i = 0; i < SCR_DW; i++) begin
            m[i] = s[SCR_LW-1];
            s    = lfsr_step(s);
        end
        return m;
    endfunction

endpackage

// File: rtl/scr_lfsr_step.sv
module scr_lfsr_step #(
    parameter int                LW   = 16,
    parameter logic [LW-1:0]     POLY = 16'hA011
) (
    input  logic [LW-1:0] cur_s,
    output logic [LW-1:0] nxt_s,
    output logic          out_bit
);
    always_comb begin
        out_bit = cur_s[LW-1];
        nxt_s   = {cur_s[LW-2:0], 1'b0} ^ (cur_s[LW-1] ? POLY : '0);
    end
endmodule

// File: rtl/scr_mask_gen.sv
module scr_mask_gen #(
    parameter int            LW   = 16,
    parameter int            DW   = 32,
    parameter logic [LW-1:0] POLY = 16'hA011
) (
    input  logic [LW-1:0] start_s,
    output logic [DW-1:0] mask,
    output logic [LW-1:0] end_s
);
    logic [LW-1:0] chain [0:DW];

    assign chain[0] = start_s;

    for (genvar i = 0; i < DW; i++) begin : g_step
        scr_lfsr_step #(.LW(LW), .POLY(POLY)) u_step (
            .cur_s  (chain[i]),
            .nxt_s  (chain[i+1]),
            .out_bit(mask[i])
        );
    end

    assign end_s = chain[DW];
endmodule

// File: rtl/scr_seq_ctl.sv
module scr_seq_ctl #(
    parameter int            LW   = 16,
    parameter logic [LW-1:0] SEED = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          adv,
    input  logic [LW-1:0] adv_s,
    output logic [LW-1:0] eff_s,
    output logic [LW-1:0] lfsr_q
);
    assign eff_s = sof ? SEED : lfsr_q;

    always_ff @(posedge clk) begin
        if (rst)      lfsr_q <= SEED;
        else if (adv) lfsr_q <= adv_s;
        else          lfsr_q <= eff_s;
    end
endmodule

// File: rtl/scr_dword_top.sv
module scr_dword_top
    import scr_pkg::*;
#(
    parameter int            DW   = SCR_DW,
    parameter int            LW   = SCR_LW,
    parameter logic [LW-1:0] POLY = SCR_POLY,
    parameter logic [LW-1:0] SEED = SCR_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_sof,
    input  logic          in_vld,
    input  logic          in_prim,
    input  logic [DW-1:0] in_dword,
    output logic          out_vld,
    output logic [DW-1:0] out_dword
);
    logic          is_data;
    logic [LW-1:0] eff_s;
    logic [LW-1:0] adv_s;
    logic [LW-1:0] lfsr_q;
    logic [DW-1:0] mask;

    assign is_data = in_vld & ~in_prim;

    scr_seq_ctl #(.LW(LW), .SEED(SEED)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .sof   (in_sof),
        .adv   (is_data),
        .adv_s (adv_s),
        .eff_s (eff_s),
        .lfsr_q(lfsr_q)
    );

    scr_mask_gen #(.LW(LW), .DW(DW), .POLY(POLY)) u_mask (
        .start_s(eff_s),
        .mask   (mask),
        .end_s  (adv_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            out_dword <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_dword <= is_data ? (in_dword ^ mask) : in_dword;
        end
    end
endmodule

// File: rtl/scr_dword_chk.sv
module scr_dword_chk
    import scr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_sof,
    input logic              in_vld,
    input logic              in_prim,
    input logic [SCR_DW-1:0] in_dword,
    input logic              out_vld,
    input logic [SCR_DW-1:0] out_dword,
    input logic [SCR_LW-1:0] lfsr_q
);
    localparam logic [SCR_DW-1:0] SMASK = seed_mask();

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_vld && out_dword == '0 && lfsr_q == SCR_SEED));

    a_r2_vld_latency: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    a_r2_no_vld: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    a_r4_sof_seed_mask: assert property (@(posedge clk) disable iff (rst)
        (in_sof && in_vld && !in_prim) |=> (out_dword == ($past(in_dword) ^ SMASK)));

    a_r5_prim_bypass: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_prim) |=> (out_dword == $past(in_dword)));

    a_r6_state_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_sof && !(in_vld && !in_prim)) |=> $stable(lfsr_q));

    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_dword));
endmodule

bind scr_dword_top scr_dword_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_sof   (in_sof),
    .in_vld   (in_vld),
    .in_prim  (in_prim),
    .in_dword (in_dword),
    .out_vld  (out_vld),
    .out_dword(out_dword),
    .lfsr_q   (lfsr_q)
);

// File: tb/tb_scr_dword_top.sv
module tb_scr_dword_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_sof, in_vld, in_prim;
    logic [31:0] in_dword;
    logic        out_vld;
    logic [31:0] out_dword;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] m_s;
    logic [31:0] m_out;

    always #2ns clk = ~clk;

    scr_dword_top dut (
        .clk(clk), .rst(rst), .in_sof(in_sof), .in_vld(in_vld),
        .in_prim(in_prim), .in_dword(in_dword),
        .out_vld(out_vld), .out_dword(out_dword)
    );

    // {sof, vld, prim, data}
    localparam int NV = 14;
    localparam logic [34:0] VEC [0:NV-1] = '{
        {3'b110, 32'h0000_0000},
        {3'b010, 32'h1234_5678},
        {3'b011, 32'h7C95_B5B5},
        {3'b000, 32'hDEAD_BEEF},
        {3'b010, 32'hFFFF_FFFF},
        {3'b111, 32'h3737_B5B5},
        {3'b010, 32'hA5A5_5A5A},
        {3'b100, 32'h0BAD_F00D},
        {3'b010, 32'h0000_0001},
        {3'b010, 32'h8000_0000},
        {3'b000, 32'h1111_1111},
        {3'b011, 32'hD5D5_B5B5},
        {3'b010, 32'hCAFE_BABE},
        {3'b110, 32'h5555_AAAA}
    };

    function automatic logic [15:0] ref_step(input logic [15:0] s);
        logic [15:0] r;
        r = s << 1;
        if (s[15]) r = r ^ 16'b1010_0000_0001_0001;
        return r;
    endfunction

    // Bit-serial reference of one cycle.
    task automatic model(input logic sof, input logic vld, input logic prim,
                         input logic [31:0] d);
        if (sof) m_s = 16'hFFFF;
        if (vld && prim) m_out = d;
        else if (vld) begin
            for (int i = 0; i < 32; i++) begin
                m_out[i] = d[i] ^ m_s[15];
                m_s = ref_step(m_s);
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] exp_d,
                         input logic exp_v);
        n_run++;
        if (out_dword !== exp_d || out_vld !== exp_v) begin
            n_fail++;
            $display("FAIL %s: dword=%h vld=%b expected dword=%h vld=%b",
                     tag, out_dword, out_vld, exp_d, exp_v);
        end
    endtask

    task automatic beat(input string tag, input logic sof, input logic vld,
                        input logic prim, input logic [31:0] d);
        @(negedge clk);
        in_sof = sof; in_vld = vld; in_prim = prim; in_dword = d;
        model(sof, vld, prim, d);
        @(posedge clk); #1;
        check(tag, m_out, vld);
    endtask

    initial begin
        logic [31:0] scr [0:2];
        logic [31:0] orig [0:2];
        rst = 1'b1; in_sof = 0; in_vld = 0; in_prim = 0; in_dword = '0;
        m_s = 16'hFFFF; m_out = '0;
        repeat (3) @(posedge clk); #1;
        check("R1 reset", 32'h0, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R1: data right after reset with no frame start uses the seed mask
        beat("R1 seed after reset", 0, 1, 0, 32'h0000_0000);
        beat("R7 second dword", 0, 1, 0, 32'h0000_0000);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            logic [34:0] v;
            v = VEC[k];
            if (!v[33])      tag = "R9 idle hold";
            else if (v[32])  tag = "R5 primitive";
            else if (v[34])  tag = "R4 frame start";
            else             tag = "R3 R7 data";
            beat(tag, v[34], v[33], v[32], v[31:0]);
        end

        // R6: long gap inside a frame, then continuation
        beat("R4 frame start", 1, 1, 0, 32'h0F0F_0F0F);
        repeat (20) beat("R6 idle", 0, 0, 0, 32'hFFFF_0000);
        beat("R6 continue after gap", 0, 1, 0, 32'h0F0F_0F0F);
        beat("R2 valid drops", 0, 0, 0, 32'h0);

        // R8: round trip through the same block
        orig[0] = 32'h0102_0304; orig[1] = 32'hF0E1_D2C3; orig[2] = 32'h7777_0000;
        for (int k = 0; k < 3; k++) begin
            beat("R8 scramble", k == 0, 1, 0, orig[k]);
            scr[k] = out_dword;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_sof = (k == 0); in_vld = 1; in_prim = 0; in_dword = scr[k];
            model(k == 0, 1, 0, scr[k]);
            @(posedge clk); #1;
            check("R8 recover", orig[k], 1'b1);
        end
        @(negedge clk); in_vld = 0; in_sof = 0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule